// File: doc/BRIEF.md
# Gap-Coded Low-Frequency Downlink Sequencer

This block sends command frames to a low-frequency tag by switching the reader's 125 kHz field on and off. Each bit is coded by how long the field stays on between two short off-gaps: a short on-time means 0 and a long on-time means 1. A frame opens with a longer off-period that puts the tag into command mode. Which bits follow depends on the operation (block write, block read, regular read, wake-up), on the page select, on whether a password is sent, and on the requested block.

The block drives a single field-enable output. All durations are counted in time units of `PRESCALE` clock cycles. With the default of 24 and a 24 MHz clock, one unit is one microsecond and one 8 µs carrier period is 192 ticks. The six durations come in on configuration inputs, so they can be tuned at run time. They are sampled each time a phase starts. The typical values in units are: start gap 248, write gap 160, zero 144, one 400, read gap 416 and programming window 20000.

After the last bit the field is switched on for a closing window. A write uses the programming window and ends with the field off. A read or regular read uses the read gap. A wake-up uses the programming window. Read and wake-up frames end with the field on, and it stays on until the next start. `done` pulses for one cycle when the closing window has elapsed.

Top module: `gapDownlinkSeq`

## Requirements
- R1: While reset is held and after its release, `fieldOn`, `busy` and `done` are 0.
- R2: A `start` sampled high while idle starts a frame. On that same clock edge `fieldOn` goes to 0 and `busy` to 1. The field then stays off for `cfgStartGap` units.
- R3: A 0 bit holds the field on for `cfgZeroLen` units and a 1 bit for `cfgOneLen` units. Every bit, including the last one, is followed by `cfgWriteGap` units with the field off.
- R4: A write frame (`op`=0) sends, in this order: 1, 1, `pageSel`, then the 32 password bits MSB first if `pwdMode`=1, then one 0 bit, then `wrData` MSB first, then `blockReq[2:0]` MSB first.
- R5: A read frame (`op`=1) sends, in this order: 1, 1, `pageSel`, then the password if `pwdMode`=1, then one 0 bit, then `blockReq[2:0]` MSB first. Only the low three bits of `blockReq` are used.
- R6: A regular read sends no block bits and is otherwise the same as a read. It is selected by `op`=2, or by `op`=1 with `blockReq`=8'hFF.
- R7: A wake-up frame (`op`=3) sends 1, 0, then the 32 password bits MSB first. The password is sent whatever the value of `pwdMode`.
- R8: After the gap that follows the last bit, the field is on for the closing window. The window is `cfgReadGap` units for `op` 1 or 2 and `cfgProgLen` units for `op` 0 or 3. When a write's window ends, the field is switched off.
- R9: `done` is high for exactly one cycle, the cycle right after the closing window. `busy` is still high in that cycle and low in the next one. After a read, regular read or wake-up the field stays on until the next frame starts.
- R10: `start` is ignored while `busy` is high. A frame in progress keeps its bit sequence and timing even if `start` and the command inputs change.
- R11: A duration input of 0 is treated as one unit.
- R12: One unit lasts exactly `PRESCALE` clock cycles, so a duration of N units keeps the field state for N×`PRESCALE` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame when idle |
| op | input | 2 | 0 write, 1 read, 2 regular read, 3 wake-up |
| pageSel | input | 1 | Page select bit |
| pwdMode | input | 1 | Send the password in write and read frames |
| password | input | 32 | Password |
| wrData | input | 32 | Data word for a write |
| blockReq | input | 8 | Block number (low 3 bits used); 8'hFF on a read selects regular read |
| cfgStartGap | input | 16 | Start gap, in units |
| cfgWriteGap | input | 16 | Gap between bits, in units |
| cfgZeroLen | input | 16 | On-time of a 0 bit, in units |
| cfgOneLen | input | 16 | On-time of a 1 bit, in units |
| cfgReadGap | input | 16 | Closing window for reads, in units |
| cfgProgLen | input | 16 | Closing window for writes and wake-up, in units |
| fieldOn | output | 1 | Field enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
`fieldOn` changes on the very edge that samples `start` or that ends a phase. The bench therefore samples on falling edges and measures every on-run and off-run in cycles, expecting N×`PRESCALE` for an N-unit duration. The closing window is counted as the cycles with the field on and `done` low. `done` must appear on the falling edge right after that count, with `fieldOn` already at its final value, and `busy` must be low on the falling edge after that. Because the bench compares run lengths rather than absolute cycle numbers, one wrong cycle in any phase shows up as a length mismatch in the check for the requirement that owns that phase.

// File: rtl/gapDlPkg.sv
package gapDlPkg;

  typedef enum logic [1:0] {
    OP_WRITE   = 2'd0,
    OP_READ    = 2'd1,
    OP_REGREAD = 2'd2,
    OP_WAKE    = 2'd3
  } dlOp_e;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_BIT   = 2'd1,
    PH_GAP   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  typedef struct packed {
    logic   loadFrame;
    logic   loadPhase;
    phase_e phaseSel;
    logic   shiftBit;
  } dlStrobe_t;

endpackage

// File: rtl/gapDlFrameReg.sv
module gapDlFrameReg
  import gapDlPkg::*;
#(
  parameter int PWD_W  = 32,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 3,
  parameter int REQ_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dlStrobe_t         strobe,
  input  logic [1:0]        op,
  input  logic              pageSel,
  input  logic              pwdMode,
  input  logic [PWD_W-1:0]  password,
  input  logic [DATA_W-1:0] wrData,
  input  logic [REQ_W-1:0]  blockReq,
  output logic              curBit,
  output logic              lastSent,
  output logic              holdRead,
  output logic              finalOn
);

  localparam int FRAME_W = 4 + PWD_W + DATA_W + BLK_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] acc;
  logic [FRAME_W-1:0] frameNext;
  logic [CNT_W-1:0]   len;
  logic               regRead;
  logic [FRAME_W-1:0] shReg;
  logic [CNT_W-1:0]   bitsLeft;
  dlOp_e              opHeld;

  // Assemble the frame right-aligned, then left-align it for MSB-first output.
  always_comb begin
    acc     = '0;
    len     = '0;
    regRead = (dlOp_e'(op) == OP_REGREAD) ||
              ((dlOp_e'(op) == OP_READ) && (blockReq == {REQ_W{1'b1}}));
    if (dlOp_e'(op) == OP_WAKE) begin
      acc = FRAME_W'(2'b10);
      len = CNT_W'(2);
      acc = (acc << PWD_W) | FRAME_W'(password);
      len = len + CNT_W'(PWD_W);
    end else begin
      acc = FRAME_W'({2'b11, pageSel});
      len = CNT_W'(3);
      if (pwdMode) begin
        acc = (acc << PWD_W) | FRAME_W'(password);
        len = len + CNT_W'(PWD_W);
      end
      acc = acc << 1;
      len = len + CNT_W'(1);
      if (dlOp_e'(op) == OP_WRITE) begin
        acc = (acc << DATA_W) | FRAME_W'(wrData);
        len = len + CNT_W'(DATA_W);
      end
      if (!regRead) begin
        acc = (acc << BLK_W) | FRAME_W'(blockReq[BLK_W-1:0]);
        len = len + CNT_W'(BLK_W);
      end
    end
    frameNext = acc << (FRAME_W - int'(len));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      bitsLeft <= '0;
      opHeld   <= OP_WRITE;
    end else if (strobe.loadFrame) begin
      shReg    <= frameNext;
      bitsLeft <= len;
      opHeld   <= dlOp_e'(op);
    end else if (strobe.shiftBit) begin
      shReg    <= shReg << 1;
      bitsLeft <= bitsLeft - CNT_W'(1);
    end
  end

  assign curBit   = shReg[FRAME_W-1];
  assign lastSent = (bitsLeft == '0);
  assign holdRead = (opHeld == OP_READ) || (opHeld == OP_REGREAD);
  assign finalOn  = (opHeld != OP_WRITE);

  // Control must never shift past the end of the assembled frame.
  assert_shift_in_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftBit |-> (bitsLeft != '0));

  // A freshly loaded frame always holds at least the four header bits.
  assert_frame_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFrame |=> (bitsLeft >= CNT_W'(4)));

endmodule

// File: rtl/gapDlPhaseTimer.sv
module gapDlPhaseTimer
  import gapDlPkg::*;
#(
  parameter int PRESCALE = 24,
  parameter int CFG_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dlStrobe_t        strobe,
  input  logic             curBit,
  input  logic             holdRead,
  input  logic [CFG_W-1:0] cfgStartGap,
  input  logic [CFG_W-1:0] cfgWriteGap,
  input  logic [CFG_W-1:0] cfgZeroLen,
  input  logic [CFG_W-1:0] cfgOneLen,
  input  logic [CFG_W-1:0] cfgReadGap,
  input  logic [CFG_W-1:0] cfgProgLen,
  output logic             expire
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRESC_MAX = PW'(PRESCALE - 1);

  logic [CFG_W-1:0] durSel;
  logic [CFG_W-1:0] durEff;
  logic [CFG_W-1:0] unitCnt;
  logic [PW-1:0]    presc;

  always_comb begin
    unique case (strobe.phaseSel)
      PH_START: durSel = cfgStartGap;
      PH_BIT:   durSel = curBit ? cfgOneLen : cfgZeroLen;
      PH_GAP:   durSel = cfgWriteGap;
      PH_HOLD:  durSel = holdRead ? cfgReadGap : cfgProgLen;
      default:  durSel = cfgStartGap;
    endcase
    durEff = (durSel == '0) ? CFG_W'(1) : durSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitCnt <= '0;
      presc   <= '0;
    end else if (strobe.loadPhase) begin
      unitCnt <= durEff;
      presc   <= '0;
    end else if (unitCnt != '0) begin
      if (presc == PRESC_MAX) begin
        presc   <= '0;
        unitCnt <= unitCnt - CFG_W'(1);
      end else begin
        presc <= presc + PW'(1);
      end
    end
  end

  assign expire = (unitCnt == CFG_W'(1)) && (presc == PRESC_MAX);

  // Every loaded phase lasts at least one unit, even with a zero setting.
  assert_unit_nonzero_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPhase |=> (unitCnt != '0));

  // The sub-unit counter restarts with each phase.
  assert_presc_restart_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPhase |=> (presc == '0));

endmodule

// File: rtl/gapDlCtrl.sv
module gapDlCtrl
  import gapDlPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      expire,
  input  logic      lastSent,
  input  logic      finalOn,
  output dlStrobe_t strobe,
  output logic      fieldOn,
  output logic      busy,
  output logic      done
);

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SGAP   = 3'd1,
    S_BITON  = 3'd2,
    S_BITGAP = 3'd3,
    S_HOLD   = 3'd4,
    S_FIN    = 3'd5
  } ctrlState_e;

  ctrlState_e state;
  logic       startAccept;

  assign startAccept = (state == S_IDLE) && start;

  always_comb begin
    strobe = '{loadFrame: 1'b0, loadPhase: 1'b0, phaseSel: PH_START, shiftBit: 1'b0};
    unique case (state)
      S_IDLE: if (start) begin
        strobe.loadFrame = 1'b1;
        strobe.loadPhase = 1'b1;
        strobe.phaseSel  = PH_START;
      end
      S_SGAP: if (expire) begin
        strobe.loadPhase = 1'b1;
        strobe.phaseSel  = PH_BIT;
      end
      S_BITON: if (expire) begin
        strobe.loadPhase = 1'b1;
        strobe.phaseSel  = PH_GAP;
        strobe.shiftBit  = 1'b1;
      end
      S_BITGAP: if (expire) begin
        strobe.loadPhase = 1'b1;
        strobe.phaseSel  = lastSent ? PH_HOLD : PH_BIT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      fieldOn <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_SGAP;
          fieldOn <= 1'b0;
        end
        S_SGAP: if (expire) begin
          state   <= S_BITON;
          fieldOn <= 1'b1;
        end
        S_BITON: if (expire) begin
          state   <= S_BITGAP;
          fieldOn <= 1'b0;
        end
        S_BITGAP: if (expire) begin
          state   <= lastSent ? S_HOLD : S_BITON;
          fieldOn <= 1'b1;
        end
        S_HOLD: if (expire) begin
          state   <= S_FIN;
          fieldOn <= finalOn;
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  assert_start_field_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    startAccept |=> (!fieldOn && busy));

  assert_field_on_expire_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fieldOn != $past(fieldOn)) |-> ($past(expire) || $past(startAccept)));

  assert_write_ends_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !finalOn) |-> !fieldOn);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_busy_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/gapDownlinkSeq.sv
module gapDownlinkSeq
  import gapDlPkg::*;
#(
  parameter int PRESCALE = 24,
  parameter int CFG_W    = 16,
  parameter int PWD_W    = 32,
  parameter int DATA_W   = 32,
  parameter int BLK_W    = 3,
  parameter int REQ_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              pageSel,
  input  logic              pwdMode,
  input  logic [PWD_W-1:0]  password,
  input  logic [DATA_W-1:0] wrData,
  input  logic [REQ_W-1:0]  blockReq,
  input  logic [CFG_W-1:0]  cfgStartGap,
  input  logic [CFG_W-1:0]  cfgWriteGap,
  input  logic [CFG_W-1:0]  cfgZeroLen,
  input  logic [CFG_W-1:0]  cfgOneLen,
  input  logic [CFG_W-1:0]  cfgReadGap,
  input  logic [CFG_W-1:0]  cfgProgLen,
  output logic              fieldOn,
  output logic              busy,
  output logic              done
);

  dlStrobe_t strobe;
  logic      curBit;
  logic      lastSent;
  logic      holdRead;
  logic      finalOn;
  logic      expire;

  gapDlCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .expire   (expire),
    .lastSent (lastSent),
    .finalOn  (finalOn),
    .strobe   (strobe),
    .fieldOn  (fieldOn),
    .busy     (busy),
    .done     (done)
  );

  gapDlFrameReg #(
    .PWD_W  (PWD_W),
    .DATA_W (DATA_W),
    .BLK_W  (BLK_W),
    .REQ_W  (REQ_W)
  ) frame_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .op       (op),
    .pageSel  (pageSel),
    .pwdMode  (pwdMode),
    .password (password),
    .wrData   (wrData),
    .blockReq (blockReq),
    .curBit   (curBit),
    .lastSent (lastSent),
    .holdRead (holdRead),
    .finalOn  (finalOn)
  );

  gapDlPhaseTimer #(
    .PRESCALE (PRESCALE),
    .CFG_W    (CFG_W)
  ) timer_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .curBit      (curBit),
    .holdRead    (holdRead),
    .cfgStartGap (cfgStartGap),
    .cfgWriteGap (cfgWriteGap),
    .cfgZeroLen  (cfgZeroLen),
    .cfgOneLen   (cfgOneLen),
    .cfgReadGap  (cfgReadGap),
    .cfgProgLen  (cfgProgLen),
    .expire      (expire)
  );

endmodule

// File: tb/gapDownlinkSeq_tb_top.sv
module gapDownlinkSeq_tb_top;

  localparam int P = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [1:0]  op;
  logic        pageSel;
  logic        pwdMode;
  logic [31:0] password;
  logic [31:0] wrData;
  logic [7:0]  blockReq;
  logic [15:0] cfgStartGap, cfgWriteGap, cfgZeroLen, cfgOneLen, cfgReadGap, cfgProgLen;
  logic        fieldOn, busy, done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic expBits [0:79];
  int   nExp;

  always #4 clk = ~clk;

  gapDownlinkSeq #(.PRESCALE(P)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .pageSel(pageSel),
    .pwdMode(pwdMode), .password(password), .wrData(wrData), .blockReq(blockReq),
    .cfgStartGap(cfgStartGap), .cfgWriteGap(cfgWriteGap), .cfgZeroLen(cfgZeroLen),
    .cfgOneLen(cfgOneLen), .cfgReadGap(cfgReadGap), .cfgProgLen(cfgProgLen),
    .fieldOn(fieldOn), .busy(busy), .done(done)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(logic [15:0] v);
    return (v == 16'd0) ? 1 : int'(v);
  endfunction

  task automatic pushBit(logic b);
    expBits[nExp] = b;
    nExp++;
  endtask

  task automatic countRun(input logic lvl, output int n);
    n = 0;
    while (fieldOn === lvl && !done && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Runs one frame and checks start gap, bits, gaps, closing window and done.
  task automatic runFrame(string req, logic [1:0] opIn, logic pg, logic pm,
                          logic [31:0] pw, logic [31:0] dt, logic [7:0] blk, int glitchAt);
    int n;
    int nOn;
    int nOff;
    int badBits;
    int badGaps;
    int firstBad;
    int firstAct;
    int firstExp;
    int expHold;
    logic expFinal;
    nExp = 0;
    if (opIn == 2'd3) begin
      pushBit(1'b1); pushBit(1'b0);
      for (int i = 31; i >= 0; i--) pushBit(pw[i]);
    end else begin
      pushBit(1'b1); pushBit(1'b1); pushBit(pg);
      if (pm) for (int i = 31; i >= 0; i--) pushBit(pw[i]);
      pushBit(1'b0);
      if (opIn == 2'd0) for (int i = 31; i >= 0; i--) pushBit(dt[i]);
      if (opIn == 2'd0 || (opIn == 2'd1 && blk != 8'hFF))
        for (int i = 2; i >= 0; i--) pushBit(blk[i]);
    end
    expHold  = (opIn == 2'd1 || opIn == 2'd2) ? eff(cfgReadGap) : eff(cfgProgLen);
    expFinal = (opIn != 2'd0);

    @(negedge clk);
    op = opIn; pageSel = pg; pwdMode = pm; password = pw; wrData = dt; blockReq = blk;
    start = 1'b1;
    if (glitchAt > 0) begin
      fork
        begin
          repeat (glitchAt) @(negedge clk);
          start = 1'b1; op = 2'd3; pageSel = ~pg; password = ~pw; blockReq = 8'h02;
          @(negedge clk);
          start = 1'b0;
        end
      join_none
    end
    @(negedge clk);
    start = 1'b0;
    check("R2", {req, " busy after start"}, int'(busy), 1);
    countRun(1'b0, n);
    check("R2", {req, " start gap cycles"}, n, eff(cfgStartGap) * P);

    badBits = 0; badGaps = 0; firstBad = -1; firstAct = 0; firstExp = 0;
    for (int b = 0; b < nExp; b++) begin
      countRun(1'b1, nOn);
      countRun(1'b0, nOff);
      if (nOn != (expBits[b] ? eff(cfgOneLen) : eff(cfgZeroLen)) * P) begin
        if (firstBad < 0) begin
          firstBad = b; firstAct = nOn;
          firstExp = (expBits[b] ? eff(cfgOneLen) : eff(cfgZeroLen)) * P;
        end
        badBits++;
      end
      if (nOff != eff(cfgWriteGap) * P) badGaps++;
    end
    if (badBits != 0)
      $display("  %s first bad bit %0d on-cycles actual=%0d expected=%0d",
               req, firstBad, firstAct, firstExp);
    check(req, "frame bit mismatches", badBits, 0);
    check("R3", {req, " gap mismatches"}, badGaps, 0);

    countRun(1'b1, n);
    check("R8", {req, " closing window cycles"}, n, expHold * P);
    check("R9", {req, " done after window"}, int'(done), 1);
    check("R8", {req, " final field"}, int'(fieldOn), int'(expFinal));
    check("R9", {req, " busy in done cycle"}, int'(busy), 1);
    @(negedge clk);
    check("R9", {req, " done one cycle"}, int'(done), 0);
    check("R9", {req, " busy low after done"}, int'(busy), 0);
  endtask

  task automatic testReset();
    check("R1", "fieldOn in reset", int'(fieldOn), 0);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "done in reset", int'(done), 0);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "fieldOn after reset", int'(fieldOn), 0);
    check("R1", "busy after reset", int'(busy), 0);
  endtask

  task automatic testWritePwd();   // R4 with password, page 1, R12 via P=3
    runFrame("R4", 2'd0, 1'b1, 1'b1, 32'hA5C3_0F81, 32'h8000_0001, 8'h06, 0);
  endtask

  task automatic testWriteNoPwd(); // R4 without password
    runFrame("R4", 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h1234_5678, 8'h03, 0);
  endtask

  task automatic testReadMasked(); // R5: 8'h0D masked to 3'b101
    runFrame("R5", 2'd1, 1'b0, 1'b1, 32'h0F0F_3C3C, 32'h0, 8'h0D, 0);
  endtask

  task automatic testRegReadFF();  // R6 via block 8'hFF
    runFrame("R6", 2'd1, 1'b1, 1'b0, 32'h0, 32'h0, 8'hFF, 0);
  endtask

  task automatic testRegReadOp();  // R6 via op 2
    runFrame("R6", 2'd2, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0, 8'h05, 0);
  endtask

  task automatic testWake();       // R7: password sent with pwdMode=0
    runFrame("R7", 2'd3, 1'b1, 1'b0, 32'h7E81_4422, 32'h0, 8'h00, 0);
  endtask

  task automatic testStaysOn();    // R9: field remains on after a wake/read
    repeat (12) @(negedge clk);
    check("R9", "field held on while idle", int'(fieldOn), 1);
    check("R9", "idle after read/wake", int'(busy), 0);
  endtask

  task automatic testStartIgnored(); // R10: mid-frame start with other command
    runFrame("R10", 2'd0, 1'b0, 1'b0, 32'h0, 32'hC001_D00D, 8'h01, 40);
  endtask

  task automatic testZeroDur();    // R11: zero setting behaves as one unit
    cfgZeroLen  = 16'd0;
    cfgWriteGap = 16'd0;
    runFrame("R11", 2'd2, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 0);
    cfgZeroLen  = 16'd3;
    cfgWriteGap = 16'd2;
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; op = 2'd0; pageSel = 1'b0; pwdMode = 1'b0;
    password = '0; wrData = '0; blockReq = '0;
    cfgStartGap = 16'd4; cfgWriteGap = 16'd2; cfgZeroLen = 16'd3;
    cfgOneLen = 16'd7; cfgReadGap = 16'd5; cfgProgLen = 16'd9;
    repeat (4) @(negedge clk);
    testReset();
    testWritePwd();
    testWriteNoPwd();
    testReadMasked();
    testStaysOn();
    testRegReadFF();
    testRegReadOp();
    testWake();
    testStaysOn();
    testStartIgnored();
    testZeroDur();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule